// File: doc/BRIEF.md
# PTP Event Packet Classifier

This block sits behind a receive header parser and decides, once per frame, whether the frame is a precision time protocol event message that should have its arrival time captured. The parser hands over the header fields it extracts (EtherType, IP protocol number, UDP source and destination ports, and the PTP version and message-type nibbles), each qualified by its own one-cycle strobe, together with a start-of-frame marker. The block keeps the fields of the current frame, checks them against the enabled filters and the selected mode, and raises a one-cycle capture request in the cycle after the message-type strobe.

Two filters can be enabled independently. The layer-2 filter recognises the PTP EtherType. The layer-4 filter recognises UDP traffic to the PTP event port, optionally also requiring that port as the source. A mode input then picks which message classes count: version-1 Sync only, version-1 Delay_Req only, any version-2 event on either path, or every frame that passes an enabled filter. The storage of the captured timestamp is done elsewhere.

Top module: `ptp_evt_classifier`

## Requirements
- R1: While reset is asserted and after it is released, `capture_o` is 0 until a message-type strobe causes a capture.
- R2: `capture_o` is 1 only in the cycle directly after a cycle with `ptp_vld` = 1, and is 0 in every other cycle.
- R3: Mode code 0 (off) and the unused codes 5, 6 and 7 never raise a capture.
- R4: The layer-2 path hits when `cfg_l2_en` = 1 and the frame's EtherType is 0x88F7.
- R5: The layer-4 path hits when `cfg_l4_en` = 1, the IP protocol is 17 (UDP) and the UDP destination port is 319.
- R6: When `cfg_sport_chk` = 1, the layer-4 path additionally requires the UDP source port to be 319; when 0 the source port is ignored.
- R7: Mode code 1 captures only on a layer-4 hit with version 1 and message value 0 (Sync); a layer-2 hit alone does not count.
- R8: Mode code 2 captures only on a layer-4 hit with version 1 and message value 1 (Delay_Req).
- R9: Mode code 3 captures when either path hits, the version is 2 and the message type is 0 to 3.
- R10: Mode code 4 captures on any version and message type whenever either path hits.
- R11: With both `cfg_l2_en` and `cfg_l4_en` at 0, no capture is ever raised, whatever the mode.
- R12: `hdr_sof` discards every field held from the previous frame; a field strobed in the same cycle as `hdr_sof` or as `ptp_vld` is used for the decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 3 | Filter mode: 0 off, 1 v1 Sync, 2 v1 Delay_Req, 3 v2 event, 4 all |
| cfg_l2_en | input | 1 | Enable the EtherType filter |
| cfg_l4_en | input | 1 | Enable the UDP port filter |
| cfg_sport_chk | input | 1 | Also require the event port as UDP source port |
| hdr_sof | input | 1 | Start of a new frame header |
| eth_vld | input | 1 | EtherType strobe |
| eth_type | input | 16 | EtherType |
| ipp_vld | input | 1 | IP protocol strobe |
| ip_proto | input | 8 | IP protocol number |
| udp_vld | input | 1 | UDP port strobe |
| udp_sport | input | 16 | UDP source port |
| udp_dport | input | 16 | UDP destination port |
| ptp_vld | input | 1 | PTP version and message-type strobe (end of header) |
| ptp_ver | input | 4 | PTP version nibble |
| ptp_msg | input | 4 | PTP message-type or control nibble |
| capture_o | output | 1 | One-cycle timestamp capture request |

## Verification
The assertions watch, on every cycle, that a capture only ever follows a message-type strobe, and that off or unused modes, a disabled filter pair, a wrong message class in the three typed modes, or a failing source port seen at decision time all leave the output low. What they cannot show is that a correct frame does raise the request, that fields from an earlier frame are dropped at start of frame while same-cycle strobes are honoured, and that the two paths combine as each mode demands; the bench's frame scenarios and its per-cycle reference model cover those.

// File: rtl/ptp_cls_pkg.sv
package ptp_cls_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF     = 3'd0,
    MODE_V1_SYNC = 3'd1,
    MODE_V1_DREQ = 3'd2,
    MODE_V2_EVT  = 3'd3,
    MODE_ALL     = 3'd4
  } cls_mode_e;

endpackage

// File: rtl/ptp_field_hold.sv
// Holds one parsed header field for the current frame and presents the
// value the decision should use in this cycle (same-cycle strobe wins).
module ptp_field_hold #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sof_i,
  input  logic         vld_i,
  input  logic [W-1:0] d_i,
  output logic         eff_vld_o,
  output logic [W-1:0] eff_d_o
);

  logic         seen_q, seen_d;
  logic [W-1:0] held_q, held_d;
  logic         held_en;

  always_comb begin
    held_en = vld_i;
    seen_d  = vld_i | (seen_q & ~sof_i);
    held_d  = vld_i ? d_i : held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
    end else begin
      seen_q <= seen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (held_en) begin
      held_q <= held_d;
    end
  end

  assign eff_vld_o = seen_d;
  assign eff_d_o   = held_d;

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld_i) |=> $stable(held_q)); // R12

  AST_SOF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_i && !vld_i) |=> !seen_q); // R12

endmodule

// File: rtl/ptp_l2_match.sv
module ptp_l2_match #(
  parameter int                ETYPE_W     = 16,
  parameter logic [ETYPE_W-1:0] MATCH_ETYPE = 16'h88F7
) (
  input  logic               en_i,
  input  logic               vld_i,
  input  logic [ETYPE_W-1:0] etype_i,
  output logic               hit_o
);

  always_comb begin
    hit_o = en_i & vld_i & (etype_i == MATCH_ETYPE);
  end

endmodule

// File: rtl/ptp_l4_match.sv
module ptp_l4_match #(
  parameter int                 PROTO_W      = 8,
  parameter int                 PORT_W       = 16,
  parameter logic [PROTO_W-1:0] MATCH_PROTO  = 8'd17,
  parameter logic [PORT_W-1:0]  MATCH_PORT   = 16'd319,
  parameter bit                 HAS_SPORT_CK = 1'b1
) (
  input  logic               en_i,
  input  logic               sport_chk_i,
  input  logic               proto_vld_i,
  input  logic [PROTO_W-1:0] proto_i,
  input  logic               port_vld_i,
  input  logic [PORT_W-1:0]  sport_i,
  input  logic [PORT_W-1:0]  dport_i,
  output logic               hit_o
);

  logic base_ok;
  logic sport_ok;

  always_comb begin
    base_ok = en_i & proto_vld_i & port_vld_i &
              (proto_i == MATCH_PROTO) & (dport_i == MATCH_PORT);
  end

  generate
    if (HAS_SPORT_CK) begin : g_sport
      always_comb begin
        sport_ok = ~sport_chk_i | (sport_i == MATCH_PORT);
      end
    end else begin : g_nosport
      always_comb begin
        sport_ok = 1'b1;
      end
    end
  endgenerate

  assign hit_o = base_ok & sport_ok;

endmodule

// File: rtl/ptp_mode_decide.sv
module ptp_mode_decide
  import ptp_cls_pkg::*;
#(
  parameter int              NIB_W    = 4,
  parameter logic [NIB_W-1:0] V1_CODE  = 4'd1,
  parameter logic [NIB_W-1:0] V2_CODE  = 4'd2,
  parameter logic [NIB_W-1:0] SYNC_VAL = 4'd0,
  parameter logic [NIB_W-1:0] DREQ_VAL = 4'd1,
  parameter logic [NIB_W-1:0] EVT_MAX  = 4'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              l2_hit_i,
  input  logic              l4_hit_i,
  input  logic              msg_vld_i,
  input  logic [NIB_W-1:0]  ver_i,
  input  logic [NIB_W-1:0]  msg_i,
  output logic              cap_o
);

  logic sel;
  logic cap_d, cap_q;
  logic any_hit;

  always_comb begin
    any_hit = l2_hit_i | l4_hit_i;
    case (mode_i)
      MODE_V1_SYNC: sel = l4_hit_i & (ver_i == V1_CODE) & (msg_i == SYNC_VAL);
      MODE_V1_DREQ: sel = l4_hit_i & (ver_i == V1_CODE) & (msg_i == DREQ_VAL);
      MODE_V2_EVT:  sel = any_hit & (ver_i == V2_CODE) & (msg_i <= EVT_MAX);
      MODE_ALL:     sel = any_hit;
      default:      sel = 1'b0;
    endcase
    cap_d = msg_vld_i & sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= 1'b0;
    end else begin
      cap_q <= cap_d;
    end
  end

  assign cap_o = cap_q;

  AST_CAP_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_q |-> $past(msg_vld_i)); // R2

  AST_NO_STROBE_NO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_vld_i) |=> !cap_q); // R2

endmodule

// File: rtl/ptp_evt_classifier.sv
module ptp_evt_classifier
  import ptp_cls_pkg::*;
#(
  parameter int                 ETYPE_W     = 16,
  parameter int                 PROTO_W     = 8,
  parameter int                 PORT_W      = 16,
  parameter int                 NIB_W       = 4,
  parameter logic [ETYPE_W-1:0] PTP_ETYPE   = 16'h88F7,
  parameter logic [PROTO_W-1:0] UDP_PROTO   = 8'd17,
  parameter logic [PORT_W-1:0]  EVT_PORT    = 16'd319,
  parameter bit                 SPORT_CK_EN = 1'b1,
  parameter int                 RST_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         cfg_mode,
  input  logic               cfg_l2_en,
  input  logic               cfg_l4_en,
  input  logic               cfg_sport_chk,
  input  logic               hdr_sof,
  input  logic               eth_vld,
  input  logic [ETYPE_W-1:0] eth_type,
  input  logic               ipp_vld,
  input  logic [PROTO_W-1:0] ip_proto,
  input  logic               udp_vld,
  input  logic [PORT_W-1:0]  udp_sport,
  input  logic [PORT_W-1:0]  udp_dport,
  input  logic               ptp_vld,
  input  logic [NIB_W-1:0]   ptp_ver,
  input  logic [NIB_W-1:0]   ptp_msg,
  output logic               capture_o
);

  localparam int PAIR_W = 2 * PORT_W;
  localparam logic [NIB_W-1:0] EVT_MAX = NIB_W'(3);

  // Reset: asserted asynchronously, released after RST_STAGES clocks.
  logic [RST_STAGES-1:0] rst_sh_q, rst_sh_d;
  logic                  rst_q_n;

  always_comb begin
    rst_sh_d = {rst_sh_q[RST_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sh_q <= '0;
    end else begin
      rst_sh_q <= rst_sh_d;
    end
  end

  assign rst_q_n = rst_sh_q[RST_STAGES-1];

  // Per-frame field storage
  logic               eth_ok, ipp_ok, udp_ok;
  logic [ETYPE_W-1:0] eth_eff;
  logic [PROTO_W-1:0] ipp_eff;
  logic [PAIR_W-1:0]  udp_eff;

  ptp_field_hold #(.W(ETYPE_W)) i_hold_eth (
    .clk(clk), .rst_n(rst_q_n), .sof_i(hdr_sof), .vld_i(eth_vld),
    .d_i(eth_type), .eff_vld_o(eth_ok), .eff_d_o(eth_eff)
  );

  ptp_field_hold #(.W(PROTO_W)) i_hold_ipp (
    .clk(clk), .rst_n(rst_q_n), .sof_i(hdr_sof), .vld_i(ipp_vld),
    .d_i(ip_proto), .eff_vld_o(ipp_ok), .eff_d_o(ipp_eff)
  );

  ptp_field_hold #(.W(PAIR_W)) i_hold_udp (
    .clk(clk), .rst_n(rst_q_n), .sof_i(hdr_sof), .vld_i(udp_vld),
    .d_i({udp_sport, udp_dport}), .eff_vld_o(udp_ok), .eff_d_o(udp_eff)
  );

  // Filters
  logic l2_hit, l4_hit;

  ptp_l2_match #(.ETYPE_W(ETYPE_W), .MATCH_ETYPE(PTP_ETYPE)) i_l2 (
    .en_i(cfg_l2_en), .vld_i(eth_ok), .etype_i(eth_eff), .hit_o(l2_hit)
  );

  ptp_l4_match #(
    .PROTO_W(PROTO_W), .PORT_W(PORT_W), .MATCH_PROTO(UDP_PROTO),
    .MATCH_PORT(EVT_PORT), .HAS_SPORT_CK(SPORT_CK_EN)
  ) i_l4 (
    .en_i(cfg_l4_en), .sport_chk_i(cfg_sport_chk),
    .proto_vld_i(ipp_ok), .proto_i(ipp_eff),
    .port_vld_i(udp_ok), .sport_i(udp_eff[PAIR_W-1:PORT_W]),
    .dport_i(udp_eff[PORT_W-1:0]), .hit_o(l4_hit)
  );

  // Mode selection and capture pulse
  ptp_mode_decide #(
    .NIB_W(NIB_W), .V1_CODE(NIB_W'(1)), .V2_CODE(NIB_W'(2)),
    .SYNC_VAL(NIB_W'(0)), .DREQ_VAL(NIB_W'(1)), .EVT_MAX(EVT_MAX)
  ) i_decide (
    .clk(clk), .rst_n(rst_q_n), .mode_i(cfg_mode),
    .l2_hit_i(l2_hit), .l4_hit_i(l4_hit), .msg_vld_i(ptp_vld),
    .ver_i(ptp_ver), .msg_i(ptp_msg), .cap_o(capture_o)
  );

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ptp_vld && (cfg_mode == 3'd0 || cfg_mode > 3'd4)) |=> !capture_o); // R3

  AST_NO_FILTER_QUIET: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ptp_vld && !cfg_l2_en && !cfg_l4_en) |=> !capture_o); // R11

  AST_SPORT_REJECT: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ptp_vld && udp_vld && cfg_sport_chk && !cfg_l2_en &&
     udp_sport != EVT_PORT) |=> !capture_o); // R6

  AST_V1_SYNC_TYPE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ptp_vld && cfg_mode == 3'd1 && (ptp_msg != 0 || ptp_ver != 1)) |=> !capture_o); // R7

  AST_V1_DREQ_TYPE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ptp_vld && cfg_mode == 3'd2 && (ptp_msg != 1 || ptp_ver != 1)) |=> !capture_o); // R8

  AST_V2_TYPE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ptp_vld && cfg_mode == 3'd3 && (ptp_ver != 2 || ptp_msg > EVT_MAX)) |=> !capture_o); // R9

endmodule

// File: tb/test_ptp_evt_classifier.sv
module test_ptp_evt_classifier;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  cfg_mode;
  logic        cfg_l2_en, cfg_l4_en, cfg_sport_chk;
  logic        hdr_sof, eth_vld, ipp_vld, udp_vld, ptp_vld;
  logic [15:0] eth_type, udp_sport, udp_dport;
  logic [7:0]  ip_proto;
  logic [3:0]  ptp_ver, ptp_msg;
  logic        capture_o;

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #5 clk = ~clk;

  ptp_evt_classifier i_ptp_evt_classifier (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_l2_en(cfg_l2_en),
    .cfg_l4_en(cfg_l4_en), .cfg_sport_chk(cfg_sport_chk), .hdr_sof(hdr_sof),
    .eth_vld(eth_vld), .eth_type(eth_type), .ipp_vld(ipp_vld),
    .ip_proto(ip_proto), .udp_vld(udp_vld), .udp_sport(udp_sport),
    .udp_dport(udp_dport), .ptp_vld(ptp_vld), .ptp_ver(ptp_ver),
    .ptp_msg(ptp_msg), .capture_o(capture_o)
  );

  // Behavioural reference: what the last frame delivered, and the decision.
  bit m_es, m_ps, m_us, exp_cap;
  int m_et, m_pr, m_sp, m_dp;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_es = 0; m_ps = 0; m_us = 0; exp_cap = 0;
      m_et = 0; m_pr = 0; m_sp = 0; m_dp = 0;
    end else begin
      bit l2, l4, want;
      if (hdr_sof) begin m_es = 0; m_ps = 0; m_us = 0; end
      if (eth_vld) begin m_es = 1; m_et = int'(eth_type); end
      if (ipp_vld) begin m_ps = 1; m_pr = int'(ip_proto); end
      if (udp_vld) begin m_us = 1; m_sp = int'(udp_sport); m_dp = int'(udp_dport); end
      l2 = cfg_l2_en && m_es && m_et == 'h88F7;
      l4 = cfg_l4_en && m_ps && m_us && m_pr == 17 && m_dp == 319 &&
           (!cfg_sport_chk || m_sp == 319);
      want = 0;
      if (ptp_vld) begin
        case (int'(cfg_mode))
          1: want = l4 && ptp_ver == 1 && ptp_msg == 0;
          2: want = l4 && ptp_ver == 1 && ptp_msg == 1;
          3: want = (l2 || l4) && ptp_ver == 2 && ptp_msg <= 3;
          4: want = l2 || l4;
          default: want = 0;
        endcase
      end
      exp_cap = want;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: capture_o=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the clock edge.
  always @(negedge clk) begin
    if (rst_n && !done) check({cur_req, " model"}, capture_o, exp_cap);
  end

  task automatic idle();
    hdr_sof = 0; eth_vld = 0; ipp_vld = 0; udp_vld = 0; ptp_vld = 0;
  endtask

  task automatic cfg(input int mode, input bit l2, input bit l4, input bit sc);
    @(negedge clk);
    cfg_mode = 3'(mode); cfg_l2_en = l2; cfg_l4_en = l4; cfg_sport_chk = sc;
  endtask

  // Frame spread over three cycles: SOF+EtherType, IP/UDP, PTP nibbles.
  task automatic frame(input bit ev, input int et, input bit uv, input int pr,
                       input int sp, input int dp, input int ve, input int ms,
                       input logic want, input string req);
    cur_req = req;
    @(negedge clk);
    idle(); hdr_sof = 1; eth_vld = ev; eth_type = 16'(et);
    @(negedge clk);
    idle(); ipp_vld = uv; udp_vld = uv; ip_proto = 8'(pr);
    udp_sport = 16'(sp); udp_dport = 16'(dp);
    @(negedge clk);
    idle(); ptp_vld = 1; ptp_ver = 4'(ve); ptp_msg = 4'(ms);
    @(negedge clk);
    idle();
    check(req, capture_o, want);
    @(negedge clk);
    check("R2", capture_o, 1'b0);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_mode = 0; cfg_l2_en = 0; cfg_l4_en = 0; cfg_sport_chk = 0;
    idle(); eth_type = 0; ip_proto = 0; udp_sport = 0; udp_dport = 0;
    ptp_ver = 0; ptp_msg = 0;
    repeat (3) @(negedge clk);
    check("R1", capture_o, 1'b0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check("R1", capture_o, 1'b0);

    // Layer-2 path in v2 event mode
    cfg(3, 1, 0, 0);
    frame(1, 'h88F7, 0, 0, 0, 0, 2, 0, 1, "R4");
    frame(1, 'h0800, 0, 0, 0, 0, 2, 0, 0, "R4");
    // Layer-4 path
    cfg(3, 0, 1, 0);
    frame(0, 0, 1, 17, 319, 319, 2, 1, 1, "R5");
    frame(0, 0, 1, 6, 319, 319, 2, 1, 0, "R5");
    frame(0, 0, 1, 17, 319, 320, 2, 1, 0, "R5");
    frame(1, 'h88F7, 0, 0, 0, 0, 2, 0, 0, "R5");
    // Source-port check
    cfg(3, 0, 1, 1);
    frame(0, 0, 1, 17, 319, 319, 2, 2, 1, "R6");
    frame(0, 0, 1, 17, 1000, 319, 2, 2, 0, "R6");
    cfg(3, 0, 1, 0);
    frame(0, 0, 1, 17, 1000, 319, 2, 2, 1, "R6");
    // Version-1 Sync
    cfg(1, 1, 1, 0);
    frame(0, 0, 1, 17, 0, 319, 1, 0, 1, "R7");
    frame(0, 0, 1, 17, 0, 319, 1, 1, 0, "R7");
    frame(0, 0, 1, 17, 0, 319, 2, 0, 0, "R7");
    frame(1, 'h88F7, 0, 0, 0, 0, 1, 0, 0, "R7");
    // Version-1 Delay_Req
    cfg(2, 0, 1, 0);
    frame(0, 0, 1, 17, 0, 319, 1, 1, 1, "R8");
    frame(0, 0, 1, 17, 0, 319, 1, 0, 0, "R8");
    // Version-2 event types
    cfg(3, 1, 1, 0);
    frame(0, 0, 1, 17, 0, 319, 2, 3, 1, "R9");
    frame(1, 'h88F7, 0, 0, 0, 0, 2, 8, 0, "R9");
    frame(1, 'h88F7, 0, 0, 0, 0, 1, 0, 0, "R9");
    // All mode
    cfg(4, 1, 1, 0);
    frame(1, 'h88F7, 0, 0, 0, 0, 0, 12, 1, "R10");
    frame(0, 0, 1, 17, 0, 319, 7, 9, 1, "R10");
    frame(1, 'h0806, 1, 17, 0, 53, 2, 0, 0, "R10");
    // Off and unused modes
    cfg(0, 1, 1, 0);
    frame(1, 'h88F7, 1, 17, 319, 319, 2, 0, 0, "R3");
    cfg(6, 1, 1, 0);
    frame(1, 'h88F7, 1, 17, 319, 319, 2, 0, 0, "R3");
    // No filter enabled
    cfg(4, 0, 0, 0);
    frame(1, 'h88F7, 1, 17, 319, 319, 2, 0, 0, "R11");
    // Per-frame state
    cfg(4, 1, 0, 0);
    frame(1, 'h88F7, 0, 0, 0, 0, 2, 0, 1, "R12");
    frame(0, 0, 0, 0, 0, 0, 2, 0, 0, "R12");
    cur_req = "R12";
    @(negedge clk);
    idle(); hdr_sof = 1; eth_vld = 1; eth_type = 16'h88F7;
    ptp_vld = 1; ptp_ver = 4'd2; ptp_msg = 4'd0;
    @(negedge clk);
    idle();
    check("R12", capture_o, 1'b1);
    // Back-to-back strobes on a held field: two pulses, then quiet
    cur_req = "R2";
    @(negedge clk);
    ptp_vld = 1;
    @(negedge clk);
    check("R2", capture_o, 1'b1);
    @(negedge clk);
    idle();
    check("R2", capture_o, 1'b1);
    @(negedge clk);
    check("R2", capture_o, 1'b0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule